// File: doc/BRIEF.md
# NAND page program sequencer

This block is the host-side engine that writes one page of a NAND flash device over an 8-bit parallel bus. The host pulses `start` with a row (page) address and a first column. It then streams bytes through a valid/ready pair. The sequencer frames them as bus cycles, using the command latch, the address latch and a write strobe. A segment ends with a byte marked `dat_last`. If `dat_jump` is set on that byte, another segment follows at column `dat_jcol`. The sequencer then moves the device's load pointer with a short two-byte column command before more data goes out.

After the last segment the sequencer commits the page and watches the ready/busy line through a two-flop synchronizer. Once the device is ready, it reads the status byte. The result comes back as a one-cycle `done` pulse with `fail` and `tmo` beside it. A device that stays busy longer than `BUSY_MAX` cycles ends the operation with a timeout. Each strobe lasts a fixed number of clock cycles, and parameters set the low and high phases of the write and read strobes.

Top module: `nand_prog_seq`

## Requirements
- R1: While reset is held, `nand_cle`, `nand_ale`, `nand_io_oe`, `busy` and `done` are 0, and `nand_we_n` and `nand_re_n` are 1.
- R2: `start` in idle produces a command cycle 0x80 (CLE=1, ALE=0), then five address cycles (ALE=1, CLE=0). The address bytes go out in this order: column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8, row bits 23:16. CLE and ALE are never high together.
- R3: Data bytes go out in stream order, one per write strobe, with CLE=0 and ALE=0. `dat_ready` is high only when the sequencer holds no byte and drives no bus cycle.
- R4: A last byte with `dat_jump`=1 is followed by command 0x85 and two address cycles holding `dat_jcol` (bits 7:0 first). The next segment's data comes after them. This may repeat any number of times.
- R5: A last byte with `dat_jump`=0 is followed by command 0x10 and then nothing more until the device has been busy and is ready again.
- R6: While `nand_rb_n` is low, no write or read strobe is issued.
- R7: When the device is ready after 0x10, the sequencer issues command 0x70 and one read strobe. `fail` equals bit 0 of the byte read (0 = success).
- R8: `done` is a single-cycle pulse. `fail` and `tmo` are high only in that cycle.
- R9: If `nand_rb_n` is still low after `BUSY_MAX` busy-wait cycles, the operation ends with `done`=1, `fail`=1 and `tmo`=1, and no 0x70 is issued.
- R10: `start` is ignored while `busy` is 1: exactly one 0x80 command appears per operation, and the latched address is used.
- R11: Every write strobe holds `nand_we_n` low for `T_WL` cycles, and every read strobe holds `nand_re_n` low for `T_RL` cycles. CLE, ALE and the data lines stay unchanged while the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a page program (taken only in idle) |
| row_addr | input | 24 | Page (row) address |
| col_addr | input | 16 | First column |
| dat_valid | input | 1 | Data byte present |
| dat_ready | output | 1 | Sequencer takes the byte this cycle |
| dat_byte | input | 8 | Data byte |
| dat_last | input | 1 | Byte ends the current segment |
| dat_jump | input | 1 | With last: another segment follows |
| dat_jcol | input | 16 | Column of the following segment |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Program failed (with done) |
| tmo | output | 1 | Busy timeout (with done) |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_oe | output | 1 | Bus drive enable |
| nand_io_out | output | 8 | Bus value driven |
| nand_io_in | input | 8 | Bus value read |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
The assertions assume that the device pulls `nand_rb_n` low only after the 0x10 commit and releases it before the next operation starts. This is the premise of the quiet-while-busy check. The bench's device model lowers the line a few cycles after it sees 0x10 and raises it after a chosen busy length. Each test then waits for the line to return high before the next request. The assertions also assume that `nand_io_in` holds still while the read strobe is low, and the model keeps the status byte fixed for the whole operation.

// File: rtl/nand_prog_seq.sv
module nand_prog_seq #(
  parameter int COL_BYTES = 2,
  parameter int ROW_BYTES = 3,
  parameter int T_WL = 2,
  parameter int T_WH = 2,
  parameter int T_RL = 3,
  parameter int T_RH = 2,
  parameter int T_WB = 4,
  parameter int BUSY_MAX = 50000
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [ROW_BYTES*8-1:0] row_addr,
  input  logic [COL_BYTES*8-1:0] col_addr,
  input  logic                   dat_valid,
  output logic                   dat_ready,
  input  logic [7:0]             dat_byte,
  input  logic                   dat_last,
  input  logic                   dat_jump,
  input  logic [COL_BYTES*8-1:0] dat_jcol,
  output logic                   busy,
  output logic                   done,
  output logic                   fail,
  output logic                   tmo,
  output logic                   nand_cle,
  output logic                   nand_ale,
  output logic                   nand_we_n,
  output logic                   nand_re_n,
  output logic                   nand_io_oe,
  output logic [7:0]             nand_io_out,
  input  logic [7:0]             nand_io_in,
  input  logic                   nand_rb_n
);

  localparam int AB   = COL_BYTES + ROW_BYTES;
  localparam int WCYC = T_WL + T_WH;
  localparam int RCYC = T_RL + T_RH;
  localparam int CM1  = (WCYC > RCYC) ? WCYC : RCYC;
  localparam int CMAX = (CM1 > T_WB) ? CM1 : T_WB;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int IW   = $clog2(AB + 1);
  localparam int BW   = $clog2(BUSY_MAX + 1);

  localparam logic [CW-1:0] C_WL   = CW'(T_WL);
  localparam logic [CW-1:0] C_WEND = CW'(WCYC - 1);
  localparam logic [CW-1:0] C_RL   = CW'(T_RL);
  localparam logic [CW-1:0] C_RSMP = CW'(T_RL - 1);
  localparam logic [CW-1:0] C_REND = CW'(RCYC - 1);
  localparam logic [CW-1:0] C_WBND = CW'(T_WB - 1);
  localparam logic [IW-1:0] I_AEND = IW'(AB - 1);
  localparam logic [IW-1:0] I_CEND = IW'(COL_BYTES - 1);
  localparam logic [BW-1:0] B_END  = BW'(BUSY_MAX - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_C80, S_ADR, S_DAT, S_C85, S_JADR, S_C10, S_WB, S_BSY, S_C70, S_RD
  } st_t;

  st_t                st;
  logic [CW-1:0]      cyc;
  logic [IW-1:0]      idx;
  logic [BW-1:0]      bcnt;
  logic [AB*8-1:0]    ash;
  logic [7:0]         dbyte;
  logic               dlast, djump, have, stat0;
  logic [COL_BYTES*8-1:0] djcol;
  logic [1:0]         rb_s;

  wire wr_st = (st == S_C80) || (st == S_ADR) || (st == S_C85) || (st == S_JADR) ||
               (st == S_C10) || (st == S_C70) || (st == S_DAT && have);
  wire wend  = (cyc == C_WEND);
  wire unused_stat = ^nand_io_in[7:1];

  assign nand_we_n  = ~(wr_st && cyc < C_WL);
  assign nand_re_n  = ~(st == S_RD && cyc < C_RL);
  assign nand_cle   = (st == S_C80) || (st == S_C85) || (st == S_C10) || (st == S_C70);
  assign nand_ale   = (st == S_ADR) || (st == S_JADR);
  assign nand_io_oe = wr_st;
  assign dat_ready  = (st == S_DAT) && !have;
  assign busy       = (st != S_IDLE);

  always_comb begin
    case (st)
      S_C80:        nand_io_out = 8'h80;
      S_C85:        nand_io_out = 8'h85;
      S_C10:        nand_io_out = 8'h10;
      S_C70:        nand_io_out = 8'h70;
      S_ADR, S_JADR: nand_io_out = ash[7:0];
      S_DAT:        nand_io_out = dbyte;
      default:      nand_io_out = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cyc <= '0;
      idx <= '0;
      bcnt <= '0;
      ash <= '0;
      dbyte <= '0;
      dlast <= 1'b0;
      djump <= 1'b0;
      djcol <= '0;
      have <= 1'b0;
      stat0 <= 1'b0;
      rb_s <= 2'b11;
      done <= 1'b0;
      fail <= 1'b0;
      tmo <= 1'b0;
    end else begin
      rb_s <= {rb_s[0], nand_rb_n};
      done <= 1'b0;
      fail <= 1'b0;
      tmo  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ash <= {row_addr, col_addr};
          cyc <= '0;
          st  <= S_C80;
        end
        S_C80, S_C85: begin
          cyc <= wend ? '0 : cyc + 1'b1;
          if (wend) begin
            idx <= '0;
            st  <= (st == S_C80) ? S_ADR : S_JADR;
          end
        end
        S_ADR, S_JADR: begin
          cyc <= wend ? '0 : cyc + 1'b1;
          if (wend) begin
            ash <= ash >> 8;
            idx <= idx + 1'b1;
            if ((st == S_ADR && idx == I_AEND) || (st == S_JADR && idx == I_CEND))
              st <= S_DAT;
          end
        end
        S_DAT: begin
          if (!have) begin
            if (dat_valid) begin
              dbyte <= dat_byte;
              dlast <= dat_last;
              djump <= dat_jump;
              djcol <= dat_jcol;
              have  <= 1'b1;
              cyc   <= '0;
            end
          end else if (wend) begin
            have <= 1'b0;
            cyc  <= '0;
            if (dlast) begin
              if (djump) begin
                ash <= {{(ROW_BYTES*8){1'b0}}, djcol};
                st  <= S_C85;
              end else begin
                st  <= S_C10;
              end
            end
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        S_C10: begin
          cyc <= wend ? '0 : cyc + 1'b1;
          if (wend) st <= S_WB;
        end
        S_WB: begin
          if (cyc == C_WBND) begin
            cyc  <= '0;
            bcnt <= '0;
            st   <= S_BSY;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        S_BSY: begin
          if (rb_s[1]) begin
            cyc <= '0;
            st  <= S_C70;
          end else if (bcnt == B_END) begin
            done <= 1'b1;
            fail <= 1'b1;
            tmo  <= 1'b1;
            st   <= S_IDLE;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        S_C70: begin
          cyc <= wend ? '0 : cyc + 1'b1;
          if (wend) st <= S_RD;
        end
        S_RD: begin
          if (cyc == C_RSMP) stat0 <= nand_io_in[0];
          if (cyc == C_REND) begin
            cyc  <= '0;
            done <= 1'b1;
            fail <= stat0;
            st   <= S_IDLE;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_prog_seq_chk.sv
module nand_prog_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       fail,
  input logic       tmo,
  input logic       dat_ready,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_io_oe,
  input logic [7:0] nand_io_out,
  input logic       nand_rb_n
);

  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  assert_ready_idle_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |-> (!nand_io_oe && nand_we_n));

  assert_quiet_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_rb_n |-> (nand_we_n && nand_re_n));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_flags_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail || tmo) |-> done);

  assert_done_ends_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_tmo_is_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> fail);

  assert_strobe_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && !$past(nand_we_n)) |->
      ($stable(nand_io_out) && $stable(nand_cle) && $stable(nand_ale)));

  assert_no_rw_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_strobe_driven_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_io_oe);

endmodule

bind nand_prog_seq nand_prog_seq_chk u_chk (.*);

// File: tb/sim_nand_prog_seq.sv
module sim_nand_prog_seq;
  localparam int CLK_P = 10;
  localparam int TWL = 2;
  localparam int TRL = 3;
  localparam int BMAX = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic start = 0, dat_valid = 0, dat_last = 0, dat_jump = 0;
  logic [23:0] row_addr = '0;
  logic [15:0] col_addr = '0, dat_jcol = '0;
  logic [7:0] dat_byte = '0, stat = 8'hC0;
  logic dat_ready, busy, done, fail, tmo;
  logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0] nand_io_out;
  logic rb = 1'b1;

  nand_prog_seq #(.T_WL(TWL), .T_RL(TRL), .BUSY_MAX(BMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .row_addr(row_addr), .col_addr(col_addr),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte), .dat_last(dat_last),
    .dat_jump(dat_jump), .dat_jcol(dat_jcol), .busy(busy), .done(done), .fail(fail), .tmo(tmo),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_oe(nand_io_oe), .nand_io_out(nand_io_out), .nand_io_in(stat), .nand_rb_n(rb));

  int n_chk = 0, n_bad = 0;
  logic [9:0] got [0:255];
  logic [9:0] expv [0:255];
  string expr [0:255];
  int ngot = 0, nexp = 0, n_rd = 0;
  int lo_we = 0, lo_re = 0, bad_we = 0, bad_re = 0;
  int rb_phase = 0, rb_cnt = 0, busy_len = 10;

  logic [23:0] row;
  int nseg;
  int slen [0:3];
  logic [15:0] scol [0:3];
  logic [7:0] sdat [0:3][0:15];

  task automatic chk(input bit ok, input string r, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // bus observer and device model, sampled between edges
  always @(negedge clk) begin
    if (!rst_n) begin
      lo_we = 0; lo_re = 0;
    end else begin
      if (!nand_we_n) lo_we++;
      else if (lo_we != 0) begin
        if (lo_we != TWL) bad_we++;
        if (ngot < 256) got[ngot] = {nand_cle, nand_ale, nand_io_out};
        ngot++;
        if (nand_cle && nand_io_out == 8'h10 && rb_phase == 0) begin
          rb_phase = 1; rb_cnt = 3;
        end
        lo_we = 0;
      end
      if (!nand_re_n) lo_re++;
      else if (lo_re != 0) begin
        if (lo_re != TRL) bad_re++;
        n_rd++;
        lo_re = 0;
      end
      case (rb_phase)
        1: if (rb_cnt == 0) begin rb = 1'b0; rb_phase = 2; rb_cnt = busy_len; end
           else rb_cnt--;
        2: if (rb_cnt == 0) begin rb = 1'b1; rb_phase = 0; end
           else rb_cnt--;
        default: ;
      endcase
    end
  end

  task automatic push(input logic [9:0] v, input string r);
    expv[nexp] = v; expr[nexp] = r; nexp++;
  endtask

  task automatic build_exp(input bit to);
    nexp = 0;
    push({2'b10, 8'h80}, "R2");
    push({2'b01, scol[0][7:0]}, "R2");
    push({2'b01, scol[0][15:8]}, "R2");
    push({2'b01, row[7:0]}, "R2");
    push({2'b01, row[15:8]}, "R2");
    push({2'b01, row[23:16]}, "R2");
    for (int s = 0; s < nseg; s++) begin
      if (s > 0) begin
        push({2'b10, 8'h85}, "R4");
        push({2'b01, scol[s][7:0]}, "R4");
        push({2'b01, scol[s][15:8]}, "R4");
      end
      for (int b = 0; b < slen[s]; b++) push({2'b00, sdat[s][b]}, "R3");
    end
    push({2'b10, 8'h10}, "R5");
    if (!to) push({2'b10, 8'h70}, "R7");
  endtask

  task automatic rand_req(input int n);
    nseg = n;
    row = 24'($urandom);
    for (int s = 0; s < n; s++) begin
      slen[s] = $urandom_range(8, 1);
      scol[s] = 16'($urandom);
      for (int b = 0; b < 16; b++) sdat[s][b] = 8'($urandom);
    end
  endtask

  task automatic drive_data(input bit dup);
    for (int s = 0; s < nseg; s++) begin
      for (int b = 0; b < slen[s]; b++) begin
        dat_valid = 1'b1;
        dat_byte  = sdat[s][b];
        dat_last  = (b == slen[s] - 1);
        dat_jump  = dat_last && (s < nseg - 1);
        dat_jcol  = (s < nseg - 1) ? scol[s < 3 ? s + 1 : 3] : 16'h0;
        if (dup && s == 0 && b == 0) begin
          start = 1'b1; row_addr = ~row; col_addr = ~scol[0];
        end
        while (!dat_ready) @(negedge clk);
        @(negedge clk);
        start = 1'b0;
      end
    end
    dat_valid = 1'b0; dat_last = 1'b0; dat_jump = 1'b0;
  endtask

  task automatic run_op(input bit fbit, input int blen, input bit dup);
    bit to, f_s, t_s, seen;
    int t, n80;
    to = (blen > BMAX);
    busy_len = blen;
    stat = {2'b11, 5'b0, fbit};
    ngot = 0; n_rd = 0; bad_we = 0; bad_re = 0;
    build_exp(to);
    @(negedge clk);
    row_addr = row; col_addr = scol[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0; f_s = 0; t_s = 0;
    fork
      drive_data(dup);
      begin
        t = 0;
        while (!done && t < 5000) begin @(negedge clk); t++; end
        if (done) begin
          seen = 1; f_s = fail; t_s = tmo;
          @(negedge clk);
          chk(done == 1'b0 && fail == 1'b0 && tmo == 1'b0, "R8", "done width", done, 0);
        end
      end
    join
    chk(seen, "R8", "done seen", seen, 1);
    chk(ngot == nexp, "R3", "write strobe count", ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      chk(got[i] == expv[i], expr[i], $sformatf("bus cycle %0d", i), got[i], expv[i]);
    chk(f_s == (to | fbit), to ? "R9" : "R7", "fail flag", f_s, to | fbit);
    chk(t_s == to, "R9", "timeout flag", t_s, to);
    chk(n_rd == (to ? 0 : 1), to ? "R9" : "R7", "status reads", n_rd, to ? 0 : 1);
    chk(bad_we == 0 && bad_re == 0, "R11", "strobe widths", bad_we + bad_re, 0);
    if (dup) begin
      n80 = 0;
      for (int i = 0; i < ngot && i < 256; i++) if (got[i] == {2'b10, 8'h80}) n80++;
      chk(n80 == 1, "R10", "0x80 count", n80, 1);
    end
    while (rb_phase != 0 || rb == 1'b0) @(negedge clk);
    chk(busy == 1'b0, "R10", "idle after op", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({nand_cle, nand_ale, nand_io_oe, busy, done} == 5'b0 && nand_we_n && nand_re_n,
        "R1", "reset outputs", {nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe, busy, done},
        7'b0011000);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: single byte, pass
    rand_req(1); slen[0] = 1; run_op(1'b0, 20, 1'b0);
    // directed: three segments with column jumps, program error (R4)
    rand_req(3); run_op(1'b1, 60, 1'b0);
    // directed: busy beyond the limit (R9)
    rand_req(2); run_op(1'b0, BMAX + 80, 1'b0);
    // directed: start pulsed during the op (R10)
    rand_req(2); run_op(1'b0, 30, 1'b1);
    // directed: full-length segments, four of them
    rand_req(4); for (int s = 0; s < 4; s++) slen[s] = 8; run_op(1'b1, 5, 1'b0);

    for (int k = 0; k < 12; k++) begin
      rand_req($urandom_range(4, 1));
      run_op(1'($urandom), $urandom_range(120, 5), 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule